// File: doc/BRIEF.md
# Downlink Command and Write-Frame Checker

This block sits behind the downlink bit slicer of a contactless transponder. Once receive mode has been entered, a start strobe hands it the incoming bit stream. It reads a short command word and either tells the rest of the chip which read or authentication operation to run, or takes in a full write frame. A write frame is an address block followed by a two-dimensional parity frame. The block checks every parity bit, the closing zero, the lock-bit pair and whether the address may be written. It then asks the reply-pattern generator for an acknowledge or a refusal and, on success, hands a word write to the memory controller.

The control is one state machine with six states. IDLE waits for `rx_start` (transition *start*). CMD gathers the four command bits. On the fourth bit it goes back to IDLE (*dispatch* for a read or authentication command, *drop* for a bad one) or moves to ADDR (*write*). ADDR gathers five address bits and moves to DATA (*address done*). DATA gathers twenty-five frame bits and moves to EVAL (*frame done*). EVAL spends one cycle judging the frame and goes to PROG (*accept*) or back to IDLE (*refuse*). PROG waits for `write_done` and returns to IDLE (*programmed*). Storage, the cipher and all bit timing are outside this block.

Top module: `cmd_frame_checker`

## Requirements
- R1: After reset `busy` is 0, and `mode_valid`, `wr_req`, `ack_req` and `nak_req` are all 0.
- R2: After `rx_start` is seen while idle, the next four accepted bits (`bit_valid` high) form the command. The first three are a 3-bit code, most significant first. The fourth is an even-parity bit: the four bits together hold an even number of ones.
- R3: Codes 001 (identifier read), 010 (user-memory read) and 011 (authentication), with good parity, give a one-cycle `mode_valid` pulse in the cycle after the fourth bit. `mode_code` carries the code. The block returns to idle with no `ack_req` or `nak_req`.
- R4: A command with odd parity, or with code 000, 100, 110 or 111, returns the block to idle at once. No `mode_valid`, `ack_req`, `nak_req` or `wr_req` is produced.
- R5: Code 101 (write word) with good parity is followed by a 5-bit address block: A3, A2, A1, A0 and then an even-parity bit.
- R6: After the address come 25 frame bits. There are four rows, each of four data bits most significant first plus an even row-parity bit, so the first data bit is bit 15 of the word. Then come four column even-parity bits (PC3..PC0, where PCi covers bit i of every row nibble) and one trailing bit that must be 0.
- R7: A write is allowed only if the address, row and column parities are all even, the trailing bit is 0, `lock_bits` reads 2'b10 (LB1=1, LB0=0), the address is below 10 and the address is not 2 or 3.
- R8: If the write is allowed, `ack_req` and `wr_req` pulse together two cycles after the last frame bit is accepted, with `wr_addr` and `wr_data` valid. `busy` then stays 1 until `write_done` is seen, which produces a second `ack_req` pulse and a return to idle.
- R9: If any check of R7 fails, a single `nak_req` pulse is issued instead, with no `wr_req`, and the block returns to idle.
- R10: `ack_req` and `nak_req` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_start | input | 1 | Receive mode entered; start of a command |
| bit_valid | input | 1 | One decoded downlink bit is present |
| bit_data | input | 1 | Value of the decoded bit |
| lock_bits | input | 2 | Lock pair {LB1, LB0} read from memory |
| write_done | input | 1 | Memory programming has finished |
| busy | output | 1 | State machine is not idle |
| mode_valid | output | 1 | One-cycle pulse: run the operation in `mode_code` |
| mode_code | output | 3 | Dispatched command code |
| wr_req | output | 1 | One-cycle memory write request |
| wr_addr | output | 4 | Word address of the write |
| wr_data | output | 16 | Word to be written |
| ack_req | output | 1 | One-cycle request for an acknowledge pattern |
| nak_req | output | 1 | One-cycle request for a refusal pattern |

## Verification
The embedded assertions watch, on every cycle, that a refusal and an acknowledge never coincide, and that a write request is only raised when the sampled lock pair was 10 and the address lies in the writable range. They also check that a write request leaves the block busy, that a refusal leaves it idle, and that a dispatch only ever carries one of the three read or authentication codes. Only the bench's sweeps can show the rest: each of the sixteen command words gets its right outcome, the data word is put together from the row nibbles in the right order, each single corrupted parity or trailing bit is caught, and the second acknowledge follows the end of programming.

// File: rtl/cfc_pkg.sv
package cfc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_ADDR,
        ST_DATA,
        ST_EVAL,
        ST_PROG
    } cfc_state_t;

    localparam logic [2:0] CODE_ID_READ = 3'b001;
    localparam logic [2:0] CODE_UM_READ = 3'b010;
    localparam logic [2:0] CODE_AUTH    = 3'b011;
    localparam logic [2:0] CODE_WRITE   = 3'b101;
endpackage

// File: rtl/cfc_cmd_decoder.sv
module cfc_cmd_decoder
    import cfc_pkg::*;
(
    input  logic [3:0] cmd_word,
    output logic       cmd_ok,
    output logic       is_write
);
    logic [2:0] code;
    logic       par_ok;

    assign code   = cmd_word[3:1];
    assign par_ok = ~(^cmd_word);

    always_comb begin
        cmd_ok   = 1'b0;
        is_write = 1'b0;
        if (par_ok) begin
            unique case (code)
                CODE_ID_READ, CODE_UM_READ, CODE_AUTH: cmd_ok = 1'b1;
                CODE_WRITE: begin
                    cmd_ok   = 1'b1;
                    is_write = 1'b1;
                end
                default: cmd_ok = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/cfc_frame_check.sv
module cfc_frame_check #(
    parameter int ADDR_BITS = 4,
    parameter int ROWS      = 4,
    parameter int COLS      = 4,
    parameter int NUM_WORDS = 10,
    parameter int ID_LO     = 2,
    parameter int ID_HI     = 3,
    localparam int ROW_LEN   = COLS + 1,
    localparam int FRAME_LEN = ROWS * ROW_LEN + COLS + 1,
    localparam int WORD_W    = ROWS * COLS
) (
    input  logic [ADDR_BITS:0]   addr_blk,
    input  logic [FRAME_LEN-1:0] frame,
    input  logic [1:0]           lock_bits,
    output logic [ADDR_BITS-1:0] addr,
    output logic [WORD_W-1:0]    word,
    output logic                 write_ok
);
    logic [ROWS-1:0] row_ok;
    logic [COLS-1:0] col_ok;
    logic            addr_par_ok;
    logic            addr_allowed;
    logic            tail_ok;

    assign addr        = addr_blk[ADDR_BITS:1];
    assign addr_par_ok = ~(^addr_blk);
    assign tail_ok     = ~frame[0];

    genvar r, c;
    generate
        for (r = 0; r < ROWS; r++) begin : g_row
            localparam int TOP = FRAME_LEN - 1 - r * ROW_LEN;
            assign word[WORD_W-1-r*COLS -: COLS] = frame[TOP -: COLS];
            assign row_ok[r] = ~(^frame[TOP -: ROW_LEN]);
        end
        for (c = 0; c < COLS; c++) begin : g_col
            logic [ROWS-1:0] col_bits;
            for (r = 0; r < ROWS; r++) begin : g_cb
                assign col_bits[r] = word[r*COLS + c];
            end
            assign col_ok[c] = ~(^col_bits ^ frame[1 + c]);
        end
    endgenerate

    always_comb begin
        addr_allowed = (int'(addr) < NUM_WORDS) &&
                       !((int'(addr) >= ID_LO) && (int'(addr) <= ID_HI));
        write_ok = addr_par_ok && (&row_ok) && (&col_ok) && tail_ok &&
                   (lock_bits == 2'b10) && addr_allowed;
    end
endmodule

// File: rtl/cmd_frame_checker.sv
module cmd_frame_checker
    import cfc_pkg::*;
#(
    parameter int ADDR_BITS = 4,
    parameter int ROWS      = 4,
    parameter int COLS      = 4,
    parameter int NUM_WORDS = 10,
    parameter int ID_LO     = 2,
    parameter int ID_HI     = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rx_start,
    input  logic        bit_valid,
    input  logic        bit_data,
    input  logic [1:0]  lock_bits,
    input  logic        write_done,
    output logic        busy,
    output logic        mode_valid,
    output logic [2:0]  mode_code,
    output logic        wr_req,
    output logic [3:0]  wr_addr,
    output logic [15:0] wr_data,
    output logic        ack_req,
    output logic        nak_req
);
    localparam int CMD_LEN   = 4;
    localparam int ADDR_LEN  = ADDR_BITS + 1;
    localparam int FRAME_LEN = ROWS * (COLS + 1) + COLS + 1;
    localparam int WORD_W    = ROWS * COLS;
    localparam int CNT_W     = $clog2(FRAME_LEN + 1);

    cfc_state_t state_q, state_d;

    logic [CNT_W-1:0]     cnt_q;
    logic [CMD_LEN-2:0]   cmd_sr;
    logic [ADDR_LEN-1:0]  addr_sr;
    logic [FRAME_LEN-1:0] data_sr;
    logic [CMD_LEN-1:0]   cmd_word;
    logic                 cmd_ok, is_write, write_ok;
    logic                 cmd_last, addr_last, data_last;
    logic [ADDR_BITS-1:0] chk_addr;
    logic [WORD_W-1:0]    chk_word;

    assign cmd_word  = {cmd_sr, bit_data};
    assign cmd_last  = bit_valid && (cnt_q == CNT_W'(CMD_LEN - 1));
    assign addr_last = bit_valid && (cnt_q == CNT_W'(ADDR_LEN - 1));
    assign data_last = bit_valid && (cnt_q == CNT_W'(FRAME_LEN - 1));
    assign busy      = (state_q != ST_IDLE);

    cfc_cmd_decoder u_dec (
        .cmd_word (cmd_word),
        .cmd_ok   (cmd_ok),
        .is_write (is_write)
    );

    cfc_frame_check #(
        .ADDR_BITS (ADDR_BITS),
        .ROWS      (ROWS),
        .COLS      (COLS),
        .NUM_WORDS (NUM_WORDS),
        .ID_LO     (ID_LO),
        .ID_HI     (ID_HI)
    ) u_chk (
        .addr_blk  (addr_sr),
        .frame     (data_sr),
        .lock_bits (lock_bits),
        .addr      (chk_addr),
        .word      (chk_word),
        .write_ok  (write_ok)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (rx_start) state_d = ST_CMD;
            ST_CMD:  if (cmd_last) state_d = (cmd_ok && is_write) ? ST_ADDR : ST_IDLE;
            ST_ADDR: if (addr_last) state_d = ST_DATA;
            ST_DATA: if (data_last) state_d = ST_EVAL;
            ST_EVAL: state_d = write_ok ? ST_PROG : ST_IDLE;
            ST_PROG: if (write_done) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register and collection datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            cmd_sr  <= '0;
            addr_sr <= '0;
            data_sr <= '0;
        end else begin
            state_q <= state_d;
            if (state_d != state_q) cnt_q <= '0;
            else if (bit_valid)     cnt_q <= cnt_q + 1'b1;
            if (bit_valid && state_q == ST_CMD)  cmd_sr  <= cmd_word[CMD_LEN-2:0];
            if (bit_valid && state_q == ST_ADDR) addr_sr <= {addr_sr[ADDR_LEN-2:0], bit_data};
            if (bit_valid && state_q == ST_DATA) data_sr <= {data_sr[FRAME_LEN-2:0], bit_data};
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_valid <= 1'b0;
            mode_code  <= '0;
            wr_req     <= 1'b0;
            wr_addr    <= '0;
            wr_data    <= '0;
            ack_req    <= 1'b0;
            nak_req    <= 1'b0;
        end else begin
            mode_valid <= 1'b0;
            wr_req     <= 1'b0;
            ack_req    <= 1'b0;
            nak_req    <= 1'b0;
            unique case (state_q)
                ST_CMD: if (cmd_last && cmd_ok && !is_write) begin
                    mode_valid <= 1'b1;
                    mode_code  <= cmd_word[CMD_LEN-1:1];
                end
                ST_EVAL: if (write_ok) begin
                    ack_req <= 1'b1;
                    wr_req  <= 1'b1;
                    wr_addr <= chk_addr;
                    wr_data <= chk_word;
                end else begin
                    nak_req <= 1'b1;
                end
                ST_PROG: if (write_done) ack_req <= 1'b1;
                default: ;
            endcase
        end
    end

    a_r10_ack_nak_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(ack_req && nak_req));
    a_r7_lock_pair: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |-> $past(lock_bits) == 2'b10);
    a_r7_addr_range: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |-> (int'(wr_addr) < NUM_WORDS) &&
                   !((int'(wr_addr) >= ID_LO) && (int'(wr_addr) <= ID_HI)));
    a_r8_busy_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |-> busy);
    a_r9_idle_after_nak: assert property (@(posedge clk) disable iff (!rst_n)
        nak_req |-> !busy && !wr_req);
    a_r3_dispatch_code: assert property (@(posedge clk) disable iff (!rst_n)
        mode_valid |-> (mode_code == CODE_ID_READ || mode_code == CODE_UM_READ ||
                        mode_code == CODE_AUTH) && !busy);
endmodule

// File: tb/tb_cmd_frame_checker.sv
module tb_cmd_frame_checker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_start = 1'b0, bit_valid = 1'b0, bit_data = 1'b0;
    logic [1:0]  lock_bits = 2'b10;
    logic        write_done = 1'b0;
    logic        busy, mode_valid, wr_req, ack_req, nak_req;
    logic [2:0]  mode_code;
    logic [3:0]  wr_addr;
    logic [15:0] wr_data;

    int n_vec = 0, n_bad = 0;
    int c_mode = 0, c_wr = 0, c_ack = 0, c_nak = 0;
    logic [2:0]  got_code = '0;
    logic [3:0]  got_addr = '0;
    logic [15:0] got_data = '0;
    bit finished = 0;

    always #4 clk = ~clk;

    cmd_frame_checker dut (
        .clk(clk), .rst_n(rst_n), .rx_start(rx_start), .bit_valid(bit_valid),
        .bit_data(bit_data), .lock_bits(lock_bits), .write_done(write_done),
        .busy(busy), .mode_valid(mode_valid), .mode_code(mode_code),
        .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data),
        .ack_req(ack_req), .nak_req(nak_req)
    );

    always @(negedge clk) begin
        if (mode_valid) begin c_mode++; got_code = mode_code; end
        if (wr_req) begin c_wr++; got_addr = wr_addr; got_data = wr_data; end
        if (ack_req) c_ack++;
        if (nak_req) c_nak++;
    end

    task automatic check(string req, int act, int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_counts();
        #1;
        c_mode = 0; c_wr = 0; c_ack = 0; c_nak = 0;
    endtask

    task automatic pulse_start();
        @(negedge clk) rx_start = 1'b1;
        @(negedge clk) rx_start = 1'b0;
    endtask

    task automatic send_bit(logic b);
        @(negedge clk) begin bit_valid = 1'b1; bit_data = b; end
        @(negedge clk) bit_valid = 1'b0;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
        #1;
    endtask

    // {address block (5), frame (25)}; corrupt: 0 none, 1 addr parity,
    // 2..5 row parity, 6..9 column parity, 10 trailing bit
    function automatic logic [29:0] build(logic [3:0] a, logic [15:0] d, int corrupt);
        logic [4:0]  ab;
        logic [24:0] fr;
        logic [3:0]  cp;
        ab = {a, ^a};
        cp = d[15:12] ^ d[11:8] ^ d[7:4] ^ d[3:0];
        for (int r = 0; r < 4; r++) begin
            logic [3:0] nib;
            nib = d[15-4*r -: 4];
            fr[24-5*r -: 5] = {nib, ^nib};
        end
        fr[4:0] = {cp, 1'b0};
        if (corrupt == 1) ab[0] = ~ab[0];
        if (corrupt >= 2 && corrupt <= 5) fr[20-5*(corrupt-2)] = ~fr[20-5*(corrupt-2)];
        if (corrupt >= 6 && corrupt <= 9) fr[1+(corrupt-6)] = ~fr[1+(corrupt-6)];
        if (corrupt == 10) fr[0] = 1'b1;
        return {ab, fr};
    endfunction

    task automatic do_write(logic [3:0] a, logic [15:0] d, logic [1:0] lk, int corrupt);
        logic [29:0] bits;
        bit ok;
        lock_bits = lk;
        clear_counts();
        pulse_start();
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
        bits = build(a, d, corrupt);
        for (int i = 29; i >= 0; i--) send_bit(bits[i]);
        settle();
        ok = (corrupt == 0) && (lk == 2'b10) && (a < 10) && (a != 2) && (a != 3);
        if (ok) begin
            check("R8 first ack", c_ack, 1);
            check("R8 write request", c_wr, 1);
            check("R8 write address", got_addr, a);
            check("R6 write data", got_data, d);
            check("R8 busy while programming", busy, 1);
            check("R10 no nak on accept", c_nak, 0);
            @(negedge clk) write_done = 1'b1;
            @(negedge clk) write_done = 1'b0;
            settle();
            check("R8 second ack", c_ack, 2);
            check("R8 idle after programming", busy, 0);
        end else begin
            check("R9 nak", c_nak, 1);
            check("R9 no write", c_wr, 0);
            check("R9 no ack", c_ack, 0);
            check("R9 idle", busy, 0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check("R1 busy", busy, 0);
        check("R1 mode_valid", mode_valid, 0);
        check("R1 wr_req", wr_req, 0);
        check("R1 ack_req", ack_req, 0);
        check("R1 nak_req", nak_req, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // stray bits while idle have no effect (R2: only after rx_start)
        clear_counts();
        send_bit(1'b0); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
        settle();
        check("R2 idle bits ignored", c_mode + c_nak + c_ack, 0);
        check("R2 idle stays idle", busy, 0);

        // all command words except the write command
        for (int c = 0; c < 16; c++) begin
            logic [3:0] w;
            logic [2:0] code;
            bit par_ok, known;
            w = 4'(c);
            code = w[3:1];
            par_ok = (^w == 1'b0);
            if (par_ok && code == 3'b101) continue;
            known = par_ok && (code == 3'b001 || code == 3'b010 || code == 3'b011);
            clear_counts();
            pulse_start();
            for (int i = 3; i >= 0; i--) send_bit(w[i]);
            settle();
            if (known) begin
                check("R3 dispatch pulse", c_mode, 1);
                check("R3 dispatch code", got_code, code);
            end else begin
                check("R4 no dispatch", c_mode, 0);
            end
            check("R4 no reply", c_ack + c_nak + c_wr, 0);
            check("R2 back to idle", busy, 0);
        end

        // write sweep: every address, every lock pair, two data patterns
        for (int lk = 0; lk < 4; lk++)
            for (int a = 0; a < 16; a++)
                for (int p = 0; p < 2; p++)
                    do_write(4'(a), 16'(p ? (a * 16'h1357 + lk * 16'h0F0F)
                                           : (16'hFFFF - a * 16'h0421)),
                             2'(lk), 0);

        // R5 R6 R7: each single-bit corruption of an allowed write
        for (int k = 1; k <= 10; k++) begin
            do_write(4'd0, 16'hB6E1, 2'b10, k);
            do_write(4'd9, 16'h5A3C, 2'b10, k);
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule